// File: doc/BRIEF.md
# Power-Stage Protection and Fault Recovery Controller

This controller sits between the digitized sensing of a switching power stage and the decoder that drives its bridges. It takes a die temperature code and three comparator flags (over-current, supply too low, supply too high). From them it produces four outputs: an active-low thermal warning, an active-low fault indication, a high-impedance command for every bridge output, and an active-low power-down release. Any fault latches at once, and the same clock edge forces the bridges to high impedance.

A latched fault is cleared in one of two ways. In manual mode the tristate control must be driven high, then low, then high again. In automatic mode the controller holds the bridges off for a programmable number of cycles and then tries again. It reloads the count for as long as the fault is still present. The controller also enforces the start-up order. Power-down is released only once the supply is good. The tristate control takes effect only after the regulators report ready. A loss of supply returns the controller to power-down.

Top module: `prot_recovery_ctrl`

## Requirements
- R1: `thwarn_n` is 0 one clock edge after `temp_code` (unsigned, degrees Celsius) exceeds 130, and is 1 one edge after it is 130 or below.
- R2: Thermal shutdown sets one edge after `temp_code` reaches 150 or more. It clears only one edge after `temp_code` is 125 or less. Between these limits it keeps its previous value.
- R3: Each of `ocp_flag`, `uv_flag`, `ov_flag` and thermal shutdown, taken alone, latches a fault while the controller is out of power-down.
- R4: The edge that latches a fault drives `fault_n` to 0 and `hiz` to 1 together. Both hold until the fault is cleared.
- R5: With `auto_mode`=0, a latched fault clears only after `tristate_in` has been seen low and is then high while no fault source is active. On that edge `fault_n` returns to 1 and `hiz` to 0.
- R6: With `auto_mode`=1, a latched fault holds `fault_n` at 0 for `retry_delay`+1 cycles and then clears if no source is active. If a source is still active, the count reloads and `hiz` stays 1.
- R7: `pd_n` is 0 while `supply_good` is 0. `pd_n` goes to 1 one edge after `supply_good` rises. `hiz` stays 1 until `reg_ready` has been seen.
- R8: `supply_good` at 0 sends the controller to power-down one edge later from any state. It also clears a latched fault, giving `pd_n`=0, `hiz`=1 and `fault_n`=1.
- R9: The three comparator flags pass through a two-stage synchronizer. `fault_n` falls on the third clock edge after a flag rises.
- R10: In operation with no fault, `tristate_in`=0 drives `hiz` to 1 one edge later and leaves `fault_n` at 1. `tristate_in`=1 drives `hiz` back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_code | input | 8 | Die temperature code, degrees Celsius |
| ocp_flag | input | 1 | Over-current comparator flag, asynchronous |
| uv_flag | input | 1 | Undervoltage comparator flag, asynchronous |
| ov_flag | input | 1 | Overvoltage comparator flag, asynchronous |
| supply_good | input | 1 | Main and logic supplies present |
| reg_ready | input | 1 | Internal regulators stable |
| tristate_in | input | 1 | Tristate control, 0 forces high impedance |
| auto_mode | input | 1 | 1 selects automatic retry, 0 selects manual clearing |
| retry_delay | input | 16 | Automatic retry delay in cycles |
| pd_n | output | 1 | Power-down release, 0 holds the stage in power-down |
| hiz | output | 1 | 1 puts all bridge outputs in high impedance |
| fault_n | output | 1 | Registered fault indication, active low |
| thwarn_n | output | 1 | Registered thermal warning, active low |

## Verification
The outputs have fixed latencies from their inputs. A temperature change reaches `thwarn_n` after one edge and `fault_n` after two. A comparator flag reaches `fault_n` after three edges. Changes on the supply, regulator and tristate inputs appear after one edge. Each task drives its inputs just after a falling edge, steps the exact number of rising edges, and samples on the next falling edge. It also samples one edge early wherever that shows the change has not yet arrived. The automatic retry window is measured by counting the consecutive falling-edge samples in which `fault_n` is low, and the count is compared with `retry_delay`+1.

// File: rtl/prot_pkg.sv
package prot_pkg;
    typedef enum logic [1:0] {
        ST_OFF = 2'd0,
        ST_ARM = 2'd1,
        ST_RUN = 2'd2
    } seq_st_e;

    typedef struct packed {
        logic warn_n;
        logic sd;
    } therm_s;
endpackage

// File: rtl/prot_sync.sv
module prot_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] s1_d, s1_q, s2_d, s2_q;

    always_comb begin
        s1_d = async_i;
        s2_d = s1_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign sync_o = s2_q;
endmodule

// File: rtl/prot_thermal.sv
module prot_thermal
    import prot_pkg::*;
#(
    parameter int TEMP_W  = 8,
    parameter int WARN_T  = 130,
    parameter int TRIP_T  = 150,
    parameter int HYST_T  = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] temp_i,
    output logic              warn_n_o,
    output logic              sd_o
);
    localparam logic [TEMP_W-1:0] WarnC = TEMP_W'(WARN_T);
    localparam logic [TEMP_W-1:0] TripC = TEMP_W'(TRIP_T);
    localparam logic [TEMP_W-1:0] RelC  = TEMP_W'(TRIP_T - HYST_T);

    therm_s d, q;

    always_comb begin
        d        = q;
        d.warn_n = !(temp_i > WarnC);
        if (!q.sd && temp_i >= TripC)
            d.sd = 1'b1;
        else if (q.sd && temp_i <= RelC)
            d.sd = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{warn_n: 1'b1, sd: 1'b0};
        else        q <= d;
    end

    assign warn_n_o = q.warn_n;
    assign sd_o     = q.sd;

    // R1
    warn_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_i > WarnC) |=> !warn_n_o);
    // R2
    sd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_o && temp_i > RelC) |=> sd_o);
    // R2
    sd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_o && temp_i < TripC) |=> !sd_o);
endmodule

// File: rtl/prot_seq.sv
module prot_seq
    import prot_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fault_cond_i,
    input  logic             supply_good_i,
    input  logic             reg_ready_i,
    input  logic             tristate_i,
    input  logic             auto_i,
    input  logic [CNT_W-1:0] delay_i,
    output logic             pd_n_o,
    output logic             hiz_o,
    output logic             fault_n_o
);
    typedef struct packed {
        seq_st_e          st;
        logic             fault;
        logic             low_seen;
        logic [CNT_W-1:0] cnt;
        logic             pd_n;
        logic             hiz;
        logic             fault_n;
    } seq_s;

    seq_s d, q;

    always_comb begin
        d = q;
        unique case (q.st)
            ST_OFF:  if (supply_good_i) d.st = ST_ARM;
            ST_ARM:  if (reg_ready_i)   d.st = ST_RUN;
            default: d.st = q.st;
        endcase

        if (q.st != ST_OFF) begin
            if (!q.fault) begin
                if (fault_cond_i) begin
                    d.fault    = 1'b1;
                    d.cnt      = delay_i;
                    d.low_seen = 1'b0;
                end
            end else if (auto_i) begin
                if (q.cnt != '0)      d.cnt   = q.cnt - 1'b1;
                else if (fault_cond_i) d.cnt  = delay_i;
                else                  d.fault = 1'b0;
            end else begin
                if (!tristate_i) begin
                    d.low_seen = 1'b1;
                end else if (q.low_seen) begin
                    d.low_seen = 1'b0;
                    if (!fault_cond_i) d.fault = 1'b0;
                end
            end
        end

        if (!supply_good_i) begin
            d.st       = ST_OFF;
            d.fault    = 1'b0;
            d.low_seen = 1'b0;
            d.cnt      = '0;
        end

        d.pd_n    = (d.st != ST_OFF);
        d.hiz     = !((d.st == ST_RUN) && tristate_i && !d.fault);
        d.fault_n = !d.fault;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.st      <= ST_OFF;
            q.hiz     <= 1'b1;
            q.fault_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign pd_n_o    = q.pd_n;
    assign hiz_o     = q.hiz;
    assign fault_n_o = q.fault_n;

    // R4
    trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_OFF && !q.fault && fault_cond_i && supply_good_i)
        |=> (!fault_n_o && hiz_o));
    // R8
    off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_good_i |=> (!pd_n_o && fault_n_o && hiz_o));
    // R7
    arm_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_ARM && !reg_ready_i) |=> hiz_o);
    // R6
    retry_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fault_n_o) && $past(auto_i) && $past(supply_good_i))
        |-> ($past(q.cnt) == '0));
    // R6
    retry_again_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.fault && auto_i && fault_cond_i && supply_good_i)
        |=> (!fault_n_o && hiz_o));
    // R5
    manual_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.fault && !auto_i && !q.low_seen && supply_good_i) |=> !fault_n_o);
endmodule

// File: rtl/prot_recovery_ctrl.sv
module prot_recovery_ctrl
    import prot_pkg::*;
#(
    parameter int TEMP_W = 8,
    parameter int CNT_W  = 16,
    parameter int WARN_T = 130,
    parameter int TRIP_T = 150,
    parameter int HYST_T = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] temp_code,
    input  logic              ocp_flag,
    input  logic              uv_flag,
    input  logic              ov_flag,
    input  logic              supply_good,
    input  logic              reg_ready,
    input  logic              tristate_in,
    input  logic              auto_mode,
    input  logic [CNT_W-1:0]  retry_delay,
    output logic              pd_n,
    output logic              hiz,
    output logic              fault_n,
    output logic              thwarn_n
);
    localparam int NFLAG = 3;

    logic [NFLAG-1:0] flags_sync;
    logic             sd;
    logic             fault_cond;

    prot_sync #(.W(NFLAG)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ov_flag, uv_flag, ocp_flag}),
        .sync_o  (flags_sync)
    );

    prot_thermal #(
        .TEMP_W (TEMP_W),
        .WARN_T (WARN_T),
        .TRIP_T (TRIP_T),
        .HYST_T (HYST_T)
    ) u_therm (
        .clk      (clk),
        .rst_n    (rst_n),
        .temp_i   (temp_code),
        .warn_n_o (thwarn_n),
        .sd_o     (sd)
    );

    assign fault_cond = (|flags_sync) | sd;

    prot_seq #(.CNT_W(CNT_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .fault_cond_i  (fault_cond),
        .supply_good_i (supply_good),
        .reg_ready_i   (reg_ready),
        .tristate_i    (tristate_in),
        .auto_i        (auto_mode),
        .delay_i       (retry_delay),
        .pd_n_o        (pd_n),
        .hiz_o         (hiz),
        .fault_n_o     (fault_n)
    );
endmodule

// File: tb/sim_prot_recovery_ctrl.sv
`timescale 1ns/1ps
module sim_prot_recovery_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  temp_code = 8'd40;
    logic        ocp_flag = 1'b0, uv_flag = 1'b0, ov_flag = 1'b0;
    logic        supply_good = 1'b0, reg_ready = 1'b0, tristate_in = 1'b0;
    logic        auto_mode = 1'b0;
    logic [15:0] retry_delay = 16'd3;
    logic        pd_n, hiz, fault_n, thwarn_n;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    prot_recovery_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .temp_code(temp_code),
        .ocp_flag(ocp_flag), .uv_flag(uv_flag), .ov_flag(ov_flag),
        .supply_good(supply_good), .reg_ready(reg_ready),
        .tristate_in(tristate_in), .auto_mode(auto_mode),
        .retry_delay(retry_delay),
        .pd_n(pd_n), .hiz(hiz), .fault_n(fault_n), .thwarn_n(thwarn_n)
    );

    task automatic chk(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic manual_toggle();
        tristate_in = 1'b0; step(1);
        tristate_in = 1'b1; step(1);
    endtask

    task automatic t_reset();
        chk(pd_n, 1'b0, "R7 reset pd_n");
        chk(hiz, 1'b1, "R7 reset hiz");
        chk(fault_n, 1'b1, "R4 reset fault_n");
        chk(thwarn_n, 1'b1, "R1 reset thwarn_n");
    endtask

    task automatic t_powerup();
        tristate_in = 1'b1;
        step(3);
        chk(pd_n, 1'b0, "R7 pd_n held without supply");
        supply_good = 1'b1; step(1);
        chk(pd_n, 1'b1, "R7 pd_n released");
        chk(hiz, 1'b1, "R7 hiz before regulators");
        step(2);
        chk(hiz, 1'b1, "R7 hiz still held");
        reg_ready = 1'b1; step(1);
        chk(hiz, 1'b0, "R7 outputs enabled after regulators");
    endtask

    task automatic t_tristate();
        tristate_in = 1'b0; step(1);
        chk(hiz, 1'b1, "R10 tristate low gives hiz");
        chk(fault_n, 1'b1, "R10 tristate toggle leaves fault_n");
        tristate_in = 1'b1; step(1);
        chk(hiz, 1'b0, "R10 tristate high enables");
        chk(fault_n, 1'b1, "R10 no fault after toggle");
    endtask

    task automatic t_thermal();
        temp_code = 8'd131; step(1);
        chk(thwarn_n, 1'b0, "R1 warn at 131");
        temp_code = 8'd130; step(1);
        chk(thwarn_n, 1'b1, "R1 no warn at 130");
        temp_code = 8'd149; step(2);
        chk(fault_n, 1'b1, "R2 no trip at 149");
        temp_code = 8'd150; step(1);
        chk(fault_n, 1'b1, "R3 thermal trip not yet");
        step(1);
        chk(fault_n, 1'b0, "R3 thermal trip");
        chk(hiz, 1'b1, "R4 hiz on thermal trip");
        temp_code = 8'd126; step(1);
        manual_toggle();
        chk(fault_n, 1'b0, "R2 shutdown held at 126");
        temp_code = 8'd125; step(1);
        chk(fault_n, 1'b0, "R5 no clear without toggle");
        manual_toggle();
        chk(fault_n, 1'b1, "R5 cleared after toggle");
        chk(hiz, 1'b0, "R5 outputs back");
        temp_code = 8'd40; step(1);
    endtask

    task automatic t_flag(input int which);
        string nm;
        nm = (which == 0) ? "ocp" : (which == 1) ? "uv" : "ov";
        case (which)
            0: ocp_flag = 1'b1;
            1: uv_flag  = 1'b1;
            default: ov_flag = 1'b1;
        endcase
        step(2);
        chk(fault_n, 1'b1, {"R9 ", nm, " not before third edge"});
        step(1);
        chk(fault_n, 1'b0, {"R3 R9 ", nm, " fault"});
        chk(hiz, 1'b1, {"R4 ", nm, " hiz"});
        step(4);
        chk(fault_n, 1'b0, {"R4 ", nm, " latched"});
        ocp_flag = 1'b0; uv_flag = 1'b0; ov_flag = 1'b0;
        step(3);
        chk(fault_n, 1'b0, {"R5 ", nm, " stays without toggle"});
        manual_toggle();
        chk(fault_n, 1'b1, {"R5 ", nm, " cleared"});
        chk(hiz, 1'b0, {"R5 ", nm, " enabled"});
    endtask

    task automatic t_auto();
        int lows;
        int guard;
        auto_mode = 1'b1;
        retry_delay = 16'd3;
        ocp_flag = 1'b1; step(1);
        ocp_flag = 1'b0;
        guard = 0;
        while (fault_n === 1'b1 && guard < 10) begin step(1); guard++; end
        lows = 0;
        while (fault_n === 1'b0 && lows < 50) begin
            if (hiz !== 1'b1) chk(hiz, 1'b1, "R6 hiz during retry wait");
            lows++; step(1);
        end
        checks++;
        if (lows != 4) begin
            errors++;
            $display("FAIL R6 retry window actual=%0d expected=%0d", lows, 4);
        end
        chk(hiz, 1'b0, "R6 resumed after delay");

        ov_flag = 1'b1; step(3);
        chk(fault_n, 1'b0, "R6 persistent fault latched");
        for (int i = 0; i < 20; i++) begin
            step(1);
            if (hiz !== 1'b1 || fault_n !== 1'b0)
                chk(hiz & ~fault_n, 1'b1, "R6 outputs stay off while fault persists");
        end
        chk(hiz, 1'b1, "R6 hiz through retries");
        ov_flag = 1'b0; step(10);
        chk(fault_n, 1'b1, "R6 cleared after fault removed");
        chk(hiz, 1'b0, "R6 outputs back after retry");
        auto_mode = 1'b0;
    endtask

    task automatic t_supply_drop();
        uv_flag = 1'b1; step(3);
        chk(fault_n, 1'b0, "R3 uv before drop");
        supply_good = 1'b0; step(1);
        chk(pd_n, 1'b0, "R8 pd_n after drop");
        chk(fault_n, 1'b1, "R8 fault cleared by drop");
        chk(hiz, 1'b1, "R8 hiz after drop");
        uv_flag = 1'b0; reg_ready = 1'b0; step(2);
        supply_good = 1'b1; step(1);
        chk(pd_n, 1'b1, "R7 repower pd_n");
        chk(hiz, 1'b1, "R7 repower hiz until ready");
        reg_ready = 1'b1; step(1);
        chk(hiz, 1'b0, "R7 repower enabled");
    endtask

    initial begin
        #(200000 * 20);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(2);
        t_reset();
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_powerup();
        t_tristate();
        t_thermal();
        t_flag(0);
        t_flag(1);
        t_flag(2);
        t_auto();
        t_supply_drop();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule